// File: doc/BRIEF.md
# Minimal Machine-Mode CSR Unit

This block is the control-and-status register file for a small 32-bit integer core. It holds only the machine-mode state that a trap-and-return flow needs. Software can reach that state, and so can the core's trap logic. It also keeps read-only 64-bit performance counters. The core issues one CSR access per cycle, giving an address, an operation and an operand. It gets the old value of the addressed register back in the same cycle. Any write takes effect at the next clock edge.

Trap entry is a one-cycle strobe. The strobe carries a cause, the faulting PC and a trap value, which the block captures. A return strobe makes the block present the saved exception PC as the next fetch address. The trap-vector register is a constant. The cycle and wall-time counters are one physical counter read at two addresses. Any address the block does not implement reads zero.

Top module: `csr_lite_unit`

## Requirements
- R1: During reset (active-low `rst_n`, synchronous), every register and counter clears to zero. Right after reset is released, all implemented addresses read zero except the trap vector.
- R2: A read of an address that is not implemented returns zero. Examples are 0x301, 0x300 and 0x344. A write to such an address has no visible effect.
- R3: Address 0x305 always reads the parameter `TRAP_VEC` (default 0x0000_0010). Writes, sets and clears to it are ignored.
- R4: `csr_op` is encoded as follows: 0 reads, 1 writes the operand, 2 ORs the operand in, and 3 clears the operand's bits. `csr_rdata` shows the value from before the access in the same cycle. The new value reads back from the next cycle. The scratch register at 0x340 is a full 32-bit read/write register.
- R5: A set or clear with a zero operand leaves the addressed register unchanged.
- R6: The exception PC at 0x341 always holds zero in bits 1:0, whether it was written by software or by trap entry.
- R7: A `trap_en` cycle captures `trap_pc` into 0x341, `trap_cause` into 0x342 and `trap_val` into 0x343. Software can also write 0x342 and 0x343 at full width.
- R8: When `trap_en` and a software write to 0x341, 0x342 or 0x343 fall in the same cycle, the trap values are stored and the software value is dropped.
- R9: `ret_pc` equals the stored exception PC in a cycle with `mret_en` high. Otherwise it is zero.
- R10: The cycle counter adds one on every clock edge out of reset. Its low half reads at 0xC00 and its high half at 0xC80.
- R11: The time addresses 0xC01 and 0xC81 read the same value as the cycle addresses.
- R12: The retired-instruction counter adds one on each clock edge with `retire` high. Its halves read at 0xC02 and 0xC82. Writes to any counter address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_en | input | 1 | A software CSR access is present this cycle |
| csr_addr | input | 12 | CSR address |
| csr_op | input | 2 | 0 read, 1 write, 2 set bits, 3 clear bits |
| csr_wdata | input | 32 | Operand for write, set or clear |
| csr_rdata | output | 32 | Value of the addressed register before the access |
| trap_en | input | 1 | Trap entry strobe |
| trap_cause | input | 32 | Cause code to capture |
| trap_pc | input | 32 | PC of the trapping instruction |
| trap_val | input | 32 | Trap value to capture |
| mret_en | input | 1 | Return-from-trap strobe |
| ret_pc | output | 32 | Stored exception PC while `mret_en` is high, else zero |
| retire | input | 1 | One instruction retired this cycle |

## Verification
Reads and `ret_pc` are combinational, so they are due in the same cycle as the address or strobe. The bench drives each access on a falling edge and samples 1 ns later. Writes, trap captures and counter increments land on the next rising edge. The bench therefore reads their results at the following falling edge, after exactly one edge. Counter values are compared with a model that the bench updates on the same rising edges. Retire pulses are counted by the bench itself.

// File: rtl/csr_lite_pkg.sv
// Package: shared widths, operation codes and CSR addresses for the CSR unit.
// Assumes a 32-bit machine word and 64-bit counters read in two halves.
package csr_lite_pkg;
    localparam int XLEN  = 32;
    localparam int CNT_W = 2 * XLEN;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } csr_op_e;

    localparam logic [11:0] A_TVEC     = 12'h305;
    localparam logic [11:0] A_SCRATCH  = 12'h340;
    localparam logic [11:0] A_EPC      = 12'h341;
    localparam logic [11:0] A_CAUSE    = 12'h342;
    localparam logic [11:0] A_TVAL     = 12'h343;
    localparam logic [11:0] A_CYC_LO   = 12'hC00;
    localparam logic [11:0] A_TIME_LO  = 12'hC01;
    localparam logic [11:0] A_RET_LO   = 12'hC02;
    localparam logic [11:0] A_CYC_HI   = 12'hC80;
    localparam logic [11:0] A_TIME_HI  = 12'hC81;
    localparam logic [11:0] A_RET_HI   = 12'hC82;
endpackage

// File: rtl/csr_event_counter.sv
// Module: csr_event_counter
// Free-running up counter that adds one on each clock edge with inc high.
// Assumes synchronous active-low reset; wraps silently at full width.
module csr_event_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // Count register: clear on reset, step on inc.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (cnt == $past(cnt) + 1'b1)); // R10

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt)); // R12
endmodule

// File: rtl/csr_trap_regs.sv
// Module: csr_trap_regs
// Holds scratch, exception PC, cause and trap value registers.
// Assumes write enables are already decoded per register. Trap entry
// overrides software writes to the three trap registers.
module csr_trap_regs
    import csr_lite_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_scratch,
    input  logic            we_epc,
    input  logic            we_cause,
    input  logic            we_tval,
    input  logic [XLEN-1:0] wval,
    input  logic            trap_en,
    input  logic [XLEN-1:0] trap_cause,
    input  logic [XLEN-1:0] trap_pc,
    input  logic [XLEN-1:0] trap_val,
    output logic [XLEN-1:0] scratch,
    output logic [XLEN-1:0] epc,
    output logic [XLEN-1:0] cause,
    output logic [XLEN-1:0] tval
);
    localparam logic [XLEN-1:0] ALIGN_MASK = ~{{(XLEN-2){1'b0}}, 2'b11};

    // Scratch register: software only.
    always_ff @(posedge clk) begin
        if (!rst_n)          scratch <= '0;
        else if (we_scratch) scratch <= wval;
    end

    // Trap registers: trap entry first, then software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc   <= '0;
            cause <= '0;
            tval  <= '0;
        end else if (trap_en) begin
            epc   <= trap_pc & ALIGN_MASK;
            cause <= trap_cause;
            tval  <= trap_val;
        end else begin
            if (we_epc)   epc   <= wval & ALIGN_MASK;
            if (we_cause) cause <= wval;
            if (we_tval)  tval  <= wval;
        end
    end

    AST_EPC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        epc[1:0] == 2'b00); // R6

    AST_TRAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_en |=> (cause == $past(trap_cause) && tval == $past(trap_val))); // R8

    AST_SCRATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !we_scratch |=> $stable(scratch)); // R5
endmodule

// File: rtl/csr_read_mux.sv
// Module: csr_read_mux
// Selects the read value for a CSR address. Unknown addresses give zero.
// Assumes the cycle counter also serves as the time counter.
module csr_read_mux
    import csr_lite_pkg::*;
#(
    parameter logic [XLEN-1:0] TRAP_VEC = 32'h0000_0010
) (
    input  logic [11:0]      addr,
    input  logic [XLEN-1:0]  scratch,
    input  logic [XLEN-1:0]  epc,
    input  logic [XLEN-1:0]  cause,
    input  logic [XLEN-1:0]  tval,
    input  logic [CNT_W-1:0] cyc,
    input  logic [CNT_W-1:0] ins,
    output logic [XLEN-1:0]  rdata
);
    // Address decode for the read port.
    always_comb begin
        case (addr)
            A_TVEC:               rdata = TRAP_VEC;
            A_SCRATCH:            rdata = scratch;
            A_EPC:                rdata = epc;
            A_CAUSE:              rdata = cause;
            A_TVAL:               rdata = tval;
            A_CYC_LO, A_TIME_LO:  rdata = cyc[XLEN-1:0];
            A_CYC_HI, A_TIME_HI:  rdata = cyc[CNT_W-1:XLEN];
            A_RET_LO:             rdata = ins[XLEN-1:0];
            A_RET_HI:             rdata = ins[CNT_W-1:XLEN];
            default:              rdata = '0;
        endcase
    end
endmodule

// File: rtl/csr_lite_unit.sv
// Module: csr_lite_unit (top)
// Minimal machine-mode CSR file: read-modify-write access, trap capture,
// return PC and cycle/instret counters. Assumes one access per cycle and
// reads that return the pre-access value combinationally.
module csr_lite_unit
    import csr_lite_pkg::*;
#(
    parameter logic [31:0] TRAP_VEC = 32'h0000_0010
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_en,
    input  logic [11:0] csr_addr,
    input  logic [1:0]  csr_op,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    input  logic        trap_en,
    input  logic [31:0] trap_cause,
    input  logic [31:0] trap_pc,
    input  logic [31:0] trap_val,
    input  logic        mret_en,
    output logic [31:0] ret_pc,
    input  logic        retire
);
    logic [XLEN-1:0]  scratch, epc, cause, tval;
    logic [CNT_W-1:0] cyc, ins;
    logic [XLEN-1:0]  new_val;
    logic             sw_we;
    csr_op_e          op;

    assign op = csr_op_e'(csr_op);

    // Read-modify-write value and write qualification.
    always_comb begin
        case (op)
            OP_WRITE: new_val = csr_wdata;
            OP_SET:   new_val = csr_rdata | csr_wdata;
            OP_CLEAR: new_val = csr_rdata & ~csr_wdata;
            default:  new_val = csr_rdata;
        endcase
        sw_we = csr_en && (op == OP_WRITE ||
                           ((op == OP_SET || op == OP_CLEAR) && csr_wdata != '0));
    end

    csr_trap_regs i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_scratch (sw_we && csr_addr == A_SCRATCH),
        .we_epc     (sw_we && csr_addr == A_EPC),
        .we_cause   (sw_we && csr_addr == A_CAUSE),
        .we_tval    (sw_we && csr_addr == A_TVAL),
        .wval       (new_val),
        .trap_en    (trap_en),
        .trap_cause (trap_cause),
        .trap_pc    (trap_pc),
        .trap_val   (trap_val),
        .scratch    (scratch),
        .epc        (epc),
        .cause      (cause),
        .tval       (tval)
    );

    // Two counters: slot 0 counts clocks (also time), slot 1 counts retires.
    for (genvar g = 0; g < 2; g++) begin : g_cnt
        logic [CNT_W-1:0] value;
        csr_event_counter #(.W(CNT_W)) i_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   ((g == 0) ? 1'b1 : retire),
            .cnt   (value)
        );
    end
    assign cyc = g_cnt[0].value;
    assign ins = g_cnt[1].value;

    csr_read_mux #(.TRAP_VEC(TRAP_VEC)) i_mux (
        .addr    (csr_addr),
        .scratch (scratch),
        .epc     (epc),
        .cause   (cause),
        .tval    (tval),
        .cyc     (cyc),
        .ins     (ins),
        .rdata   (csr_rdata)
    );

    // Return address: stored exception PC only while returning.
    assign ret_pc = mret_en ? epc : '0;

    AST_RET_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !mret_en |-> ret_pc == '0); // R9

    AST_RET_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mret_en |-> ret_pc[1:0] == 2'b00); // R6

    AST_TVEC_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        csr_addr == A_TVEC |-> csr_rdata == TRAP_VEC); // R3
endmodule

// File: tb/test_csr_lite_unit.sv
// Directed bench for csr_lite_unit: one task per scenario.
module test_csr_lite_unit;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] TVEC = 32'h0000_0010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_en = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [1:0]  csr_op = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        trap_en = 1'b0;
    logic [31:0] trap_cause = '0, trap_pc = '0, trap_val = '0;
    logic        mret_en = 1'b0;
    logic [31:0] ret_pc;
    logic        retire = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [63:0] m_cyc = '0;

    csr_lite_unit #(.TRAP_VEC(TVEC)) i_csr_lite_unit (
        .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_addr(csr_addr),
        .csr_op(csr_op), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .trap_en(trap_en), .trap_cause(trap_cause), .trap_pc(trap_pc),
        .trap_val(trap_val), .mret_en(mret_en), .ret_pc(ret_pc),
        .retire(retire)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench model of the clock counter, stepped on the same edges.
    always @(posedge clk) begin
        if (!rst_n) m_cyc <= '0;
        else        m_cyc <= m_cyc + 1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Combinational read: drive on falling edge, sample 1 ns later.
    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        csr_en = 1'b1; csr_addr = a; csr_op = 2'd0; csr_wdata = '0;
        #1 v = csr_rdata;
        csr_en = 1'b0;
    endtask

    // One access that spans one rising edge.
    task automatic acc(input logic [11:0] a, input logic [1:0] op, input logic [31:0] d);
        @(negedge clk);
        csr_en = 1'b1; csr_addr = a; csr_op = op; csr_wdata = d;
        @(negedge clk);
        csr_en = 1'b0; csr_op = 2'd0; csr_wdata = '0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(12'h340, v); check("R1 scratch", v, 0);
        rd(12'h341, v); check("R1 epc", v, 0);
        rd(12'h342, v); check("R1 cause", v, 0);
        rd(12'h343, v); check("R1 tval", v, 0);
        rd(12'hC02, v); check("R1 instret", v, 0);
    endtask

    task automatic t_unimpl;
        logic [31:0] v;
        acc(12'h301, 2'd1, 32'hFFFF_FFFF);
        rd(12'h301, v); check("R2 0x301", v, 0);
        rd(12'h300, v); check("R2 0x300", v, 0);
        rd(12'h344, v); check("R2 0x344", v, 0);
    endtask

    task automatic t_tvec;
        logic [31:0] v;
        acc(12'h305, 2'd1, 32'hDEAD_BEEF);
        rd(12'h305, v); check("R3 after write", v, TVEC);
        acc(12'h305, 2'd3, 32'hFFFF_FFFF);
        rd(12'h305, v); check("R3 after clear", v, TVEC);
    endtask

    task automatic t_scratch;
        logic [31:0] v;
        @(negedge clk);
        csr_en = 1'b1; csr_addr = 12'h340; csr_op = 2'd1; csr_wdata = 32'hA5A5_0F0F;
        #1 check("R4 old value in access cycle", csr_rdata, 0);
        @(negedge clk);
        csr_en = 1'b0;
        rd(12'h340, v); check("R4 write", v, 32'hA5A5_0F0F);
        acc(12'h340, 2'd2, 32'h0000_F000);
        rd(12'h340, v); check("R4 set", v, 32'hA5A5_FF0F);
        acc(12'h340, 2'd3, 32'hA000_000F);
        rd(12'h340, v); check("R4 clear", v, 32'h05A5_FF00);
        acc(12'h340, 2'd2, 32'h0);
        rd(12'h340, v); check("R5 set zero", v, 32'h05A5_FF00);
        acc(12'h340, 2'd3, 32'h0);
        rd(12'h340, v); check("R5 clear zero", v, 32'h05A5_FF00);
    endtask

    task automatic t_epc_sw;
        logic [31:0] v;
        acc(12'h341, 2'd1, 32'h1234_5677);
        rd(12'h341, v); check("R6 sw write aligned", v, 32'h1234_5674);
        acc(12'h341, 2'd2, 32'h0000_0003);
        rd(12'h341, v); check("R6 set low bits", v, 32'h1234_5674);
    endtask

    task automatic t_trap;
        logic [31:0] v;
        acc(12'h342, 2'd1, 32'h0000_0055);
        rd(12'h342, v); check("R7 sw cause", v, 32'h55);
        acc(12'h343, 2'd1, 32'hCAFE_0001);
        rd(12'h343, v); check("R7 sw tval", v, 32'hCAFE_0001);
        // Trap and software write to cause in the same cycle.
        @(negedge clk);
        trap_en = 1'b1; trap_cause = 32'h0000_0002; trap_pc = 32'h0000_1003;
        trap_val = 32'h0BAD_C0DE;
        csr_en = 1'b1; csr_addr = 12'h342; csr_op = 2'd1; csr_wdata = 32'h7777_7777;
        @(negedge clk);
        trap_en = 1'b0; csr_en = 1'b0;
        rd(12'h342, v); check("R8 cause trap wins", v, 32'h2);
        rd(12'h341, v); check("R7 epc captured aligned", v, 32'h0000_1000);
        rd(12'h343, v); check("R7 tval captured", v, 32'h0BAD_C0DE);
    endtask

    task automatic t_mret;
        @(negedge clk);
        #1 check("R9 idle ret_pc", ret_pc, 0);
        mret_en = 1'b1;
        #1 check("R9 ret_pc", ret_pc, 32'h0000_1000);
        @(negedge clk);
        mret_en = 1'b0;
        #1 check("R9 ret_pc drops", ret_pc, 0);
    endtask

    task automatic t_counters;
        logic [31:0] v, base;
        rd(12'hC00, v); check("R10 cycle lo", v, m_cyc[31:0]);
        repeat (7) @(negedge clk);
        rd(12'hC00, v); check("R10 cycle lo later", v, m_cyc[31:0]);
        rd(12'hC80, v); check("R10 cycle hi", v, m_cyc[63:32]);
        rd(12'hC01, v); check("R11 time lo", v, m_cyc[31:0]);
        rd(12'hC81, v); check("R11 time hi", v, m_cyc[63:32]);
        rd(12'hC02, base);
        @(negedge clk); retire = 1'b1;
        repeat (5) @(negedge clk);
        retire = 1'b0;
        repeat (3) @(negedge clk);
        rd(12'hC02, v); check("R12 instret +5", v, base + 5);
        rd(12'hC82, v); check("R12 instret hi", v, 0);
        acc(12'hC02, 2'd1, 32'hFFFF_0000);
        rd(12'hC02, v); check("R12 instret write ignored", v, base + 5);
        acc(12'hC00, 2'd1, 32'h0);
        rd(12'hC00, v); check("R12 cycle write ignored", v, m_cyc[31:0]);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual hung, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unimpl();
        t_tvec();
        t_scratch();
        t_epc_sw();
        t_trap();
        t_mret();
        t_counters();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule